// File: doc/BRIEF.md
# Split-Word Frequency Register Loader

This block takes 16-bit configuration words, delivered one per cycle on a parallel write strobe, and steers them into a small set of 24-bit frequency registers and one 12-bit control register. Each word carries a 4-bit register address in its upper nibble and a 12-bit payload below it. Every frequency register is split into a low half and a high half, and each half has an address of its own. There are two frequency registers: a start frequency and a frequency step.

One bit of the control register selects how the halves are loaded. In paired mode a low-half write is held in a staging buffer. Both halves are committed together in a single cycle when the matching high-half write arrives, so a downstream reader never sees a frequency built from one new half and one old half. In split mode each write lands in its half on its own. The serial shifter that assembles the words, and anything that consumes the registers, sit outside this block.

Top module: `freq_word_loader`

## Requirements
- R1: A word is split as address = bits 15:12 and payload = bits 11:0. The address map is: 0x0 control, 0x2 start low half (bits 11:0), 0x3 start high half (bits 23:12), 0x4 step low half, 0x5 step high half.
- R2: While reset is asserted, and after reset, both frequency registers read 0 and the control register reads 0x003. Reset also drops any staged low half.
- R3: A write to address 0x0 loads the payload into the control register, with bits 1:0 always forced to 1. Bit 11 selects paired mode (1) or split mode (0). The new value is visible one cycle after the strobe.
- R4: In split mode a low-half write changes only bits 11:0 of the addressed register, and a high-half write changes only bits 23:12. Each change is visible one cycle after the strobe.
- R5: In paired mode a low-half write changes no output. It only stages the payload for its register.
- R6: In paired mode a high-half write to the same register as the staged low half loads all 24 bits in one cycle, taking the low half from the stage. The stage is then emptied.
- R7: In paired mode a high-half write with no staged low half changes nothing.
- R8: Any write to a different address, including a control write, an unmapped write or a low-half write to the other register, discards the staged half. A later high-half write then makes no commit.
- R9: Writes to unmapped addresses (0x1, 0x6 to 0xF) change no output.
- R10: Cycles with the write strobe low change no output, and they do not discard a staged half.
- R11: A write to one frequency register never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| wr_en_i | input | 1 | Write strobe, one word per cycle while high |
| wr_word_i | input | 16 | Address nibble and 12-bit payload |
| start_freq_o | output | 24 | Committed start frequency |
| delta_freq_o | output | 24 | Committed frequency step |
| ctrl_o | output | 12 | Control register contents |
| paired_mode_o | output | 1 | Control bit 11: paired load mode active |

## Verification
Every register result, whether a control update, a split-mode half write or a paired commit, appears exactly one clock edge after the strobe that causes it. The bench drives each word on a falling edge and compares all outputs on the next falling edge, after that single rising edge. A staged low half produces no visible change, so the bench confirms it only through the commit, or absence of a commit, that follows the next high-half write. Reset clears the outputs asynchronously and is checked one nanosecond after it is asserted. The synchronized release takes two rising edges, and the bench waits three cycles before its next write.

// File: rtl/freq_ldr_pkg.sv
`timescale 1ns/1ps
package freq_ldr_pkg;

  localparam int ADDR_W    = 4;
  localparam int HALF_W    = 12;
  localparam int WORD_W    = ADDR_W + HALF_W;
  localparam int NUM_FREQ  = 2;
  localparam int PAIR_BIT  = 11;

  localparam logic [ADDR_W-1:0] ADDR_CTRL      = 4'h0;
  localparam int                ADDR_FREQ_BASE = 2;
  localparam logic [HALF_W-1:0] CTRL_RESV_MASK = 12'h003;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_CTRL,
    KIND_LO,
    KIND_HI
  } wkind_e;

  // Address of one half of frequency register idx (hi selects the upper half).
  function automatic logic [ADDR_W-1:0] freq_addr(input int idx, input bit hi);
    return ADDR_W'(ADDR_FREQ_BASE + 2 * idx + (hi ? 1 : 0));
  endfunction

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/freq_addr_decode.sv
`timescale 1ns/1ps
module freq_addr_decode
  import freq_ldr_pkg::*;
#(
  parameter int NFREQ = NUM_FREQ,
  parameter int HW    = HALF_W,
  localparam int IDX_W = (NFREQ > 1) ? $clog2(NFREQ) : 1
) (
  input  logic                  wr_en_i,
  input  logic [ADDR_W+HW-1:0]  word_i,
  output wkind_e                kind_o,
  output logic [IDX_W-1:0]      idx_o,
  output logic [HW-1:0]         data_o
);

  logic [ADDR_W-1:0] addr;

  assign addr   = word_i[ADDR_W+HW-1:HW];
  assign data_o = word_i[HW-1:0];

  always_comb begin
    kind_o = KIND_NONE;
    idx_o  = '0;
    if (wr_en_i) begin
      if (addr == ADDR_CTRL) begin
        kind_o = KIND_CTRL;
      end
      for (int i = 0; i < NFREQ; i++) begin
        if (addr == freq_addr(i, 1'b0)) begin
          kind_o = KIND_LO;
          idx_o  = IDX_W'(i);
        end
        if (addr == freq_addr(i, 1'b1)) begin
          kind_o = KIND_HI;
          idx_o  = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/freq_pair_stager.sv
`timescale 1ns/1ps
module freq_pair_stager
  import freq_ldr_pkg::*;
#(
  parameter int NFREQ = NUM_FREQ,
  parameter int HW    = HALF_W,
  localparam int IDX_W = (NFREQ > 1) ? $clog2(NFREQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  wkind_e            kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [HW-1:0]     data_i,
  input  logic              paired_i,
  output logic [NFREQ-1:0]  lo_we_o,
  output logic [NFREQ-1:0]  hi_we_o,
  output logic [HW-1:0]     lo_data_o,
  output logic [HW-1:0]     hi_data_o
);

  logic             pend_v_q,   pend_v_d;
  logic [IDX_W-1:0] pend_idx_q, pend_idx_d;
  logic [HW-1:0]    pend_dat_q, pend_dat_d;
  logic             pend_en;

  // Next-state and write-enable steering.
  always_comb begin
    lo_we_o    = '0;
    hi_we_o    = '0;
    lo_data_o  = data_i;
    hi_data_o  = data_i;
    pend_v_d   = pend_v_q;
    pend_idx_d = pend_idx_q;
    pend_dat_d = pend_dat_q;
    pend_en    = 1'b0;
    if (wr_i) begin
      // Any write consumes or discards the stage unless it refills it.
      pend_v_d = 1'b0;
      if (paired_i) begin
        unique case (kind_i)
          KIND_LO: begin
            pend_v_d   = 1'b1;
            pend_idx_d = idx_i;
            pend_dat_d = data_i;
            pend_en    = 1'b1;
          end
          KIND_HI: begin
            if (pend_v_q && (pend_idx_q == idx_i)) begin
              lo_we_o[idx_i] = 1'b1;
              hi_we_o[idx_i] = 1'b1;
              lo_data_o      = pend_dat_q;
            end
          end
          default: ;
        endcase
      end else begin
        unique case (kind_i)
          KIND_LO: lo_we_o[idx_i] = 1'b1;
          KIND_HI: hi_we_o[idx_i] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      pend_dat_q <= '0;
    end else begin
      pend_v_q <= pend_v_d;
      if (pend_en) begin
        pend_idx_q <= pend_idx_d;
        pend_dat_q <= pend_dat_d;
      end
    end
  end

endmodule

// File: rtl/freq_half_reg.sv
`timescale 1ns/1ps
module freq_half_reg #(
  parameter int HW = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [HW-1:0]   lo_d_i,
  input  logic [HW-1:0]   hi_d_i,
  output logic [2*HW-1:0] q_o
);

  logic [HW-1:0] lo_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
    end else if (lo_we_i) begin
      lo_q <= lo_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
    end else if (hi_we_i) begin
      hi_q <= hi_d_i;
    end
  end

  assign q_o = {hi_q, lo_q};

endmodule

// File: rtl/ctrl_word_reg.sv
`timescale 1ns/1ps
module ctrl_word_reg #(
  parameter int            HW        = 12,
  parameter logic [HW-1:0] RESV_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [HW-1:0] d_i,
  output logic [HW-1:0] q_o
);

  logic [HW-1:0] ctrl_q;
  logic [HW-1:0] ctrl_d;

  assign ctrl_d = d_i | RESV_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= RESV_MASK;
    end else if (we_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign q_o = ctrl_q;

endmodule

// File: rtl/freq_word_loader.sv
`timescale 1ns/1ps
module freq_word_loader
  import freq_ldr_pkg::*;
#(
  parameter int HW = HALF_W,
  localparam int WW    = ADDR_W + HW,
  localparam int FW    = 2 * HW,
  localparam int NFREQ = 2,
  localparam int IDX_W = 1,
  localparam int F_START = 0,
  localparam int F_DELTA = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [WW-1:0] wr_word_i,
  output logic [FW-1:0] start_freq_o,
  output logic [FW-1:0] delta_freq_o,
  output logic [HW-1:0] ctrl_o,
  output logic          paired_mode_o
);

  logic             rst_sync_n;
  wkind_e           kind;
  logic [IDX_W-1:0] idx;
  logic [HW-1:0]    data;
  logic [NFREQ-1:0] lo_we;
  logic [NFREQ-1:0] hi_we;
  logic [HW-1:0]    lo_data;
  logic [HW-1:0]    hi_data;
  logic [FW-1:0]    freq_q [NFREQ];
  logic [HW-1:0]    ctrl_q;

  rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  freq_addr_decode #(.NFREQ(NFREQ), .HW(HW)) i_decode (
    .wr_en_i (wr_en_i),
    .word_i  (wr_word_i),
    .kind_o  (kind),
    .idx_o   (idx),
    .data_o  (data)
  );

  ctrl_word_reg #(.HW(HW), .RESV_MASK(CTRL_RESV_MASK)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .we_i   (kind == KIND_CTRL),
    .d_i    (data),
    .q_o    (ctrl_q)
  );

  freq_pair_stager #(.NFREQ(NFREQ), .HW(HW)) i_stager (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_i      (wr_en_i),
    .kind_i    (kind),
    .idx_i     (idx),
    .data_i    (data),
    .paired_i  (ctrl_q[PAIR_BIT]),
    .lo_we_o   (lo_we),
    .hi_we_o   (hi_we),
    .lo_data_o (lo_data),
    .hi_data_o (hi_data)
  );

  for (genvar g = 0; g < NFREQ; g++) begin : g_freq
    freq_half_reg #(.HW(HW)) i_freq (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .lo_we_i (lo_we[g]),
      .hi_we_i (hi_we[g]),
      .lo_d_i  (lo_data),
      .hi_d_i  (hi_data),
      .q_o     (freq_q[g])
    );
  end

  assign start_freq_o  = freq_q[F_START];
  assign delta_freq_o  = freq_q[F_DELTA];
  assign ctrl_o        = ctrl_q;
  assign paired_mode_o = ctrl_q[PAIR_BIT];

endmodule

// File: rtl/freq_word_loader_chk.sv
`timescale 1ns/1ps
module freq_word_loader_chk
  import freq_ldr_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W+HW-1:0] wr_word_i,
  input logic [2*HW-1:0]   start_freq_o,
  input logic [2*HW-1:0]   delta_freq_o,
  input logic [HW-1:0]     ctrl_o
);

  logic [ADDR_W-1:0] addr;
  logic              mapped;

  assign addr   = wr_word_i[ADDR_W+HW-1:HW];
  assign mapped = (addr == ADDR_CTRL) || (addr == freq_addr(0, 1'b0)) ||
                  (addr == freq_addr(0, 1'b1)) || (addr == freq_addr(1, 1'b0)) ||
                  (addr == freq_addr(1, 1'b1));

  AST_CTRL_RESV_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    ctrl_o[1:0] == 2'b11);  // R3

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en_i |=> $stable(start_freq_o) && $stable(delta_freq_o) && $stable(ctrl_o));  // R10

  AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i && !mapped |=> $stable(start_freq_o) && $stable(delta_freq_o) && $stable(ctrl_o));  // R9

  AST_PAIRED_LO_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i && ctrl_o[PAIR_BIT] &&
    ((addr == freq_addr(0, 1'b0)) || (addr == freq_addr(1, 1'b0)))
    |=> $stable(start_freq_o) && $stable(delta_freq_o));  // R5

  AST_SPLIT_LO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i && !ctrl_o[PAIR_BIT] && (addr == freq_addr(0, 1'b0))
    |=> (start_freq_o[HW-1:0] == $past(wr_word_i[HW-1:0])) &&
        $stable(start_freq_o[2*HW-1:HW]) && $stable(delta_freq_o));  // R4

  AST_PAIRED_HI_WHOLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i && ctrl_o[PAIR_BIT] && (addr == freq_addr(0, 1'b1))
    |=> $stable(start_freq_o) ||
        (start_freq_o[2*HW-1:HW] == $past(wr_word_i[HW-1:0])));  // R6

  AST_STEP_WRITE_KEEPS_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i && ((addr == freq_addr(1, 1'b0)) || (addr == freq_addr(1, 1'b1)))
    |=> $stable(start_freq_o));  // R11

endmodule

bind freq_word_loader freq_word_loader_chk #(.HW(HW)) i_chk (
  .clk_i        (clk_i),
  .rst_n        (rst_sync_n),
  .wr_en_i      (wr_en_i),
  .wr_word_i    (wr_word_i),
  .start_freq_o (start_freq_o),
  .delta_freq_o (delta_freq_o),
  .ctrl_o       (ctrl_o)
);

// File: tb/test_freq_word_loader.sv
`timescale 1ns/1ps
module test_freq_word_loader;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [15:0] wr_word_i;
  logic [23:0] start_freq_o;
  logic [23:0] delta_freq_o;
  logic [11:0] ctrl_o;
  logic        paired_mode_o;

  int errs   = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  freq_word_loader i_freq_word_loader (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_word_i     (wr_word_i),
    .start_freq_o  (start_freq_o),
    .delta_freq_o  (delta_freq_o),
    .ctrl_o        (ctrl_o),
    .paired_mode_o (paired_mode_o)
  );

  // {strobe, word, expected start, expected step, expected control, requirement}
  localparam int NVEC = 25;
  localparam logic [80:0] VEC [NVEC] = '{
    {1'b1, 16'h2abc, 24'h000abc, 24'h000000, 12'h003, 4'd4},   // R1 R4 split start low
    {1'b1, 16'h3123, 24'h123abc, 24'h000000, 12'h003, 4'd4},   // R4 split start high
    {1'b1, 16'h4555, 24'h123abc, 24'h000555, 12'h003, 4'd11},  // R11 step low
    {1'b1, 16'h50f0, 24'h123abc, 24'h0f0555, 12'h003, 4'd4},   // R4 step high
    {1'b1, 16'h1fff, 24'h123abc, 24'h0f0555, 12'h003, 4'd9},   // R9 unmapped 0x1
    {1'b1, 16'h9777, 24'h123abc, 24'h0f0555, 12'h003, 4'd9},   // R9 unmapped 0x9
    {1'b0, 16'h2fff, 24'h123abc, 24'h0f0555, 12'h003, 4'd10},  // R10 strobe low
    {1'b1, 16'h0800, 24'h123abc, 24'h0f0555, 12'h803, 4'd3},   // R3 paired on, resv forced
    {1'b1, 16'h2111, 24'h123abc, 24'h0f0555, 12'h803, 4'd5},   // R5 stage start low
    {1'b0, 16'h0000, 24'h123abc, 24'h0f0555, 12'h803, 4'd10},  // R10 idle keeps stage
    {1'b1, 16'h3222, 24'h222111, 24'h0f0555, 12'h803, 4'd6},   // R6 commit both halves
    {1'b1, 16'h3333, 24'h222111, 24'h0f0555, 12'h803, 4'd7},   // R7 high with empty stage
    {1'b1, 16'h4444, 24'h222111, 24'h0f0555, 12'h803, 4'd5},   // R5 stage step low
    {1'b1, 16'h2999, 24'h222111, 24'h0f0555, 12'h803, 4'd8},   // R8 restage on start
    {1'b1, 16'h5aaa, 24'h222111, 24'h0f0555, 12'h803, 4'd8},   // R8 step high mismatched
    {1'b1, 16'h4bbb, 24'h222111, 24'h0f0555, 12'h803, 4'd5},   // R5 stage step low
    {1'b1, 16'hf000, 24'h222111, 24'h0f0555, 12'h803, 4'd9},   // R9 unmapped 0xF
    {1'b1, 16'h5ccc, 24'h222111, 24'h0f0555, 12'h803, 4'd8},   // R8 stage was dropped
    {1'b1, 16'h4246, 24'h222111, 24'h0f0555, 12'h803, 4'd5},   // R5 stage step low
    {1'b1, 16'h5135, 24'h222111, 24'h135246, 12'h803, 4'd6},   // R6 step commit
    {1'b1, 16'h0ffc, 24'h222111, 24'h135246, 12'hfff, 4'd3},   // R3 low bits forced
    {1'b1, 16'h2010, 24'h222111, 24'h135246, 12'hfff, 4'd5},   // R5 stage start low
    {1'b1, 16'h0000, 24'h222111, 24'h135246, 12'h003, 4'd8},   // R8 control write drops stage
    {1'b1, 16'h3abc, 24'habc111, 24'h135246, 12'h003, 4'd4},   // R4 split high only
    {1'b1, 16'h2fed, 24'habcfed, 24'h135246, 12'h003, 4'd4}    // R4 split low only
  };

  task automatic check(input int req, input logic [23:0] es, input logic [23:0] ed,
                       input logic [11:0] ec);
    checks++;
    if (start_freq_o !== es || delta_freq_o !== ed || ctrl_o !== ec ||
        paired_mode_o !== ec[11]) begin
      errs++;
      $display("FAIL R%0d: start=%h step=%h ctrl=%h mode=%b expected start=%h step=%h ctrl=%h mode=%b",
               req, start_freq_o, delta_freq_o, ctrl_o, paired_mode_o, es, ed, ec, ec[11]);
    end
  endtask

  // Drive on a falling edge; the result is due after the next rising edge.
  task automatic write(input logic en, input logic [15:0] w);
    wr_en_i   = en;
    wr_word_i = w;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_ni    = 1'b0;
    wr_en_i   = 1'b0;
    wr_word_i = '0;
    repeat (3) @(negedge clk_i);
    check(2, 24'h0, 24'h0, 12'h003);  // R2 during reset
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(2, 24'h0, 24'h0, 12'h003);  // R2 after release

    for (int i = 0; i < NVEC; i++) begin
      write(VEC[i][80], VEC[i][79:64]);
      check(int'(VEC[i][3:0]), VEC[i][63:40], VEC[i][39:16], VEC[i][15:4]);
    end

    // R2: asynchronous reset mid-run also drops a staged half.
    write(1'b1, 16'h0800);
    write(1'b1, 16'h20aa);
    rst_ni = 1'b0;
    #1;
    check(2, 24'h0, 24'h0, 12'h003);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    write(1'b1, 16'h0800);
    write(1'b1, 16'h30bb);
    check(2, 24'h0, 24'h0, 12'h803);  // R2 R7 no commit after reset
    write(1'b1, 16'h20cc);
    write(1'b1, 16'h30dd);
    check(6, 24'h0dd0cc, 24'h0, 12'h803);  // R6 commit after reset
    write(1'b1, 16'h4123);
    write(1'b1, 16'h1000);
    write(1'b1, 16'h5456);
    check(8, 24'h0dd0cc, 24'h0, 12'h803);  // R8 R9 unmapped write between halves

    done = 1'b1;
    finish_run();
  end

endmodule